// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. It copies bytes from a source address to a destination address through a simple byte-wide memory master. It moves the data in bursts of 1, 2, 4 or 8 bytes. Bursts make up a block, and a block can be repeated a set number of times or without end. Software programs the channel through a small register port. A transfer starts from a manual request bit or, when selected, from a hardware trigger pin. Each trigger moves one whole block, or only one burst when single-shot mode is on.

The source and destination address each have their own step direction: fixed, up or down. Each also has its own reload point, at which it returns to its programmed start value: after every burst, after every block, at the end of the whole transfer, or never. The channel reports pending and busy states. It also keeps sticky done and error flags, which are cleared by writing 1.

Every byte costs two cycles. The read address is driven with `mem_rd`. The memory returns the byte on `mem_rdata` in the next cycle. In that cycle the byte is driven out with `mem_wr` at the destination address.

Top module: `dma_channel`

## Requirements
- R1: After reset, or after writing 1 to CTRL bit 1 (channel reset), every register reads 0, and `mem_rd` and `mem_wr` are low. The registers are CTRL (0), STATUS (1), ADDRMODE (2), COUNT (3), REPEAT (4), SRC (5) and DST (6).
- R2: Each byte is read at the current source address while `mem_rd` is high. In the next cycle it is written to the current destination address while `mem_wr` is high, carrying the data returned by the memory. The two strobes are never high together.
- R3: CTRL[5:4] selects the burst size: code 0, 1, 2 or 3 gives 1, 2, 4 or 8 bytes. When single-shot (CTRL[3]) is set, one trigger moves exactly one burst and the channel stays enabled.
- R4: When single-shot is clear, one trigger moves a whole block of COUNT bytes. A COUNT of 0 means 65536 bytes. While the channel is enabled, reading COUNT returns the bytes left in the current block.
- R5: When repeat (CTRL[2]) is set, the transfer lasts REPEAT blocks, and each block needs its own trigger. A REPEAT of 0 repeats without end.
- R6: ADDRMODE[1:0] sets the source direction and ADDRMODE[5:4] sets the destination direction. The codes are 0 fixed, 1 increment and 2 decrement, applied once per byte.
- R7: ADDRMODE[3:2] sets the source reload point and ADDRMODE[7:6] sets the destination reload point. The codes are 0 never, 1 after each burst, 2 after each block and 3 at the end of the transfer. Reload returns the address to the value last written to SRC or DST.
- R8: Writing CTRL with bit 0 and bit 6 set makes a manual request, and bit 6 reads 0 again once the transfer starts. A pulse on `trig_in` is a request only while CTRL[7] and the enable bit are both set. Otherwise it is ignored.
- R9: At the end of the last block, the enable bit clears and STATUS[2] (done) sets. Writing 1 to a STATUS flag bit clears that flag.
- R10: Clearing the enable bit after a transfer has started stops the memory strobes and sets STATUS[3] (error).
- R11: If COUNT is not a multiple of the burst size, an enable write leaves the channel disabled and sets the error flag.
- R12: STATUS[1] (pending) is high from the cycle after a request until the transfer starts. STATUS[0] (busy) is high while a burst or block is moving. Busy is never high while the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data for reg_addr |
| trig_in | input | 1 | Hardware transfer trigger |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 24 | Memory byte address |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| mem_wdata | output | 8 | Write data |

## Verification
The copy engine is driven with different combinations of address direction, reload point, burst size and trigger mode. Each combination leaves a different trace of destination addresses and data bytes. An up-counting block with no source reload tells a per-burst step apart from a per-byte step. A down-counting source written to a fixed destination exposes a swapped direction code. A burst-reload source paired with a block-reload destination shows whether each reload event fires at the right boundary. Single-shot and block triggering are compared by the number of bytes moved per trigger. The infinite repeat case is told apart from a finite count by the channel staying enabled after several blocks.

// File: rtl/dma_ch_pkg.sv
package dma_ch_pkg;

    typedef enum logic [1:0] {DIR_FIXED = 2'd0, DIR_INC = 2'd1, DIR_DEC = 2'd2, DIR_RSVD = 2'd3} dir_e;
    typedef enum logic [1:0] {RLD_NONE = 2'd0, RLD_BURST = 2'd1, RLD_BLOCK = 2'd2, RLD_XFER = 2'd3} rld_e;
    typedef enum logic [1:0] {S_IDLE = 2'd0, S_RD = 2'd1, S_WR = 2'd2} seq_st_e;

    // one address's settings: reload point in the upper pair, direction in the lower
    typedef struct packed {
        rld_e rld;
        dir_e dir;
    } amode_t;

    typedef struct packed {
        logic burst_end;
        logic block_end;
        logic xfer_end;
    } seq_evt_t;

    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_STATUS = 3'd1;
    localparam logic [2:0] REG_AMODE  = 3'd2;
    localparam logic [2:0] REG_COUNT  = 3'd3;
    localparam logic [2:0] REG_REPEAT = 3'd4;
    localparam logic [2:0] REG_SRC    = 3'd5;
    localparam logic [2:0] REG_DST    = 3'd6;

    function automatic logic [3:0] burst_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
    import dma_ch_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ch_rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  amode_t        mode,
    input  seq_evt_t      evt,
    output logic [AW-1:0] cur
);
    logic [AW-1:0] base;
    logic [AW-1:0] stepped;
    logic          reload_now;

    always_comb begin
        unique case (mode.dir)
            DIR_INC: stepped = cur + AW'(1);
            DIR_DEC: stepped = cur - AW'(1);
            default: stepped = cur;
        endcase
        reload_now = (mode.rld == RLD_BURST && evt.burst_end) ||
                     (mode.rld == RLD_BLOCK && evt.block_end) ||
                     (mode.rld == RLD_XFER  && evt.xfer_end);
    end

    always_ff @(posedge clk) begin
        if (rst || ch_rst) begin
            base <= '0;
            cur  <= '0;
        end else if (load) begin
            base <= load_val;
            cur  <= load_val;
        end else if (step) begin
            cur <= reload_now ? base : stepped;
        end
    end
endmodule

// File: rtl/dma_ch_seq.sv
module dma_ch_seq
    import dma_ch_pkg::*;
#(
    parameter int CW = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ch_rst,
    input  logic          start_load,
    input  logic          abort,
    input  logic          en,
    input  logic          pend,
    input  logic          single,
    input  logic          rpt,
    input  logic [1:0]    bcode,
    input  logic [CW-1:0] cnt_cfg,
    input  logic [RW-1:0] rep_cfg,
    output logic          take,
    output logic          busy,
    output logic          in_xfer,
    output logic          mem_rd,
    output logic          mem_wr,
    output seq_evt_t      evt,
    output logic [CW:0]   cnt_rem,
    output logic [RW-1:0] rep_rem
);
    seq_st_e    st;
    logic [2:0] beat;
    logic [3:0] nbytes;
    logic       beat_last;
    logic [CW:0] full_cnt;

    assign nbytes    = burst_bytes(bcode);
    assign beat_last = ({1'b0, beat} == nbytes - 4'd1);
    assign full_cnt  = (cnt_cfg == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, cnt_cfg};
    assign take      = (st == S_IDLE) && en && pend && !abort;
    assign busy      = (st != S_IDLE);
    assign mem_rd    = (st == S_RD);
    assign mem_wr    = (st == S_WR);

    always_comb begin
        evt.burst_end = mem_wr && beat_last;
        evt.block_end = mem_wr && (cnt_rem == (CW+1)'(1));
        evt.xfer_end  = evt.block_end && (!rpt || rep_rem == RW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || ch_rst) begin
            st      <= S_IDLE;
            beat    <= '0;
            in_xfer <= 1'b0;
            cnt_rem <= '0;
            rep_rem <= '0;
        end else if (abort) begin
            st      <= S_IDLE;
            beat    <= '0;
            in_xfer <= 1'b0;
        end else begin
            if (start_load) begin
                cnt_rem <= full_cnt;
                rep_rem <= rep_cfg;
                beat    <= '0;
            end
            unique case (st)
                S_IDLE: if (take) begin
                    st      <= S_RD;
                    in_xfer <= 1'b1;
                end
                S_RD: st <= S_WR;
                S_WR: begin
                    beat    <= beat_last ? 3'd0 : beat + 3'd1;
                    cnt_rem <= evt.block_end ? full_cnt : cnt_rem - (CW+1)'(1);
                    if (evt.block_end && rpt && rep_rem != '0)
                        rep_rem <= rep_rem - RW'(1);
                    if (evt.xfer_end)
                        in_xfer <= 1'b0;
                    if (evt.block_end || (single && evt.burst_end))
                        st <= S_IDLE;
                    else
                        st <= S_RD;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_ch_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          trig_in,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    input  logic [7:0]    mem_rdata,
    output logic [7:0]    mem_wdata
);
    localparam int NADDR = 2;   // 0: source, 1: destination

    logic en_q, single_q, rpt_q, trig_sel_q, man_req_q, pend_hw_q, done_q, err_q;
    logic [1:0]    bcode_q;
    logic [CW-1:0] cnt_cfg;
    logic [RW-1:0] rep_cfg;
    amode_t        amode [NADDR];
    logic [AW-1:0] acur  [NADDR];
    logic [CW:0]   cnt_rem;
    logic [RW-1:0] rep_rem;
    seq_evt_t      evt;
    logic take, busy, in_xfer, pend;

    logic wr_ctrl, ch_rst, aligned, en_on, en_bad, en_off, abort, req_new;

    assign wr_ctrl = reg_we && reg_addr == REG_CTRL;
    assign ch_rst  = wr_ctrl && reg_wdata[1];
    assign aligned = (cnt_cfg[3:0] & (burst_bytes(reg_wdata[5:4]) - 4'd1)) == 4'd0;
    assign en_on   = wr_ctrl && !ch_rst && reg_wdata[0] && !en_q && aligned;
    assign en_bad  = wr_ctrl && !ch_rst && reg_wdata[0] && !en_q && !aligned;
    assign en_off  = wr_ctrl && !ch_rst && !reg_wdata[0] && en_q;
    assign abort   = en_off && in_xfer;
    assign req_new = wr_ctrl && !ch_rst && reg_wdata[0] && reg_wdata[6] && (en_q || aligned);
    assign pend    = man_req_q || pend_hw_q;

    always_ff @(posedge clk) begin
        if (rst || ch_rst) begin
            {en_q, single_q, rpt_q, trig_sel_q, man_req_q, pend_hw_q, done_q, err_q} <= '0;
            bcode_q  <= '0;
            cnt_cfg  <= '0;
            rep_cfg  <= '0;
            amode[0] <= '0;
            amode[1] <= '0;
        end else begin
            if (take) begin
                man_req_q <= 1'b0;
                pend_hw_q <= 1'b0;
            end
            if (en_q && trig_sel_q && trig_in)
                pend_hw_q <= 1'b1;
            if (evt.xfer_end) begin
                en_q      <= 1'b0;
                done_q    <= 1'b1;
                man_req_q <= 1'b0;
                pend_hw_q <= 1'b0;
            end
            if (wr_ctrl) begin
                single_q   <= reg_wdata[3];
                rpt_q      <= reg_wdata[2];
                bcode_q    <= reg_wdata[5:4];
                trig_sel_q <= reg_wdata[7];
                if (en_on)   en_q <= 1'b1;
                if (en_bad)  err_q <= 1'b1;
                if (en_off) begin
                    en_q      <= 1'b0;
                    man_req_q <= 1'b0;
                    pend_hw_q <= 1'b0;
                    if (in_xfer) err_q <= 1'b1;
                end
                if (req_new) man_req_q <= 1'b1;
            end
            if (reg_we && reg_addr == REG_STATUS) begin
                if (reg_wdata[2]) done_q <= 1'b0;
                if (reg_wdata[3]) err_q  <= 1'b0;
            end
            if (reg_we && reg_addr == REG_AMODE) begin
                amode[0] <= amode_t'(reg_wdata[3:0]);
                amode[1] <= amode_t'(reg_wdata[7:4]);
            end
            if (reg_we && reg_addr == REG_COUNT)  cnt_cfg <= reg_wdata[CW-1:0];
            if (reg_we && reg_addr == REG_REPEAT) rep_cfg <= reg_wdata[RW-1:0];
        end
    end

    dma_ch_seq #(.CW(CW), .RW(RW)) i_seq (
        .clk(clk), .rst(rst), .ch_rst(ch_rst), .start_load(en_on), .abort(abort),
        .en(en_q), .pend(pend), .single(single_q), .rpt(rpt_q), .bcode(bcode_q),
        .cnt_cfg(cnt_cfg), .rep_cfg(rep_cfg), .take(take), .busy(busy),
        .in_xfer(in_xfer), .mem_rd(mem_rd), .mem_wr(mem_wr), .evt(evt),
        .cnt_rem(cnt_rem), .rep_rem(rep_rem)
    );

    for (genvar g = 0; g < NADDR; g++) begin : g_addr
        localparam logic [2:0] MY_REG = (g == 0) ? REG_SRC : REG_DST;
        dma_addr_unit #(.AW(AW)) i_addr (
            .clk(clk), .rst(rst), .ch_rst(ch_rst),
            .load(reg_we && reg_addr == MY_REG), .load_val(reg_wdata),
            .step(mem_wr), .mode(amode[g]), .evt(evt), .cur(acur[g])
        );
    end

    assign mem_addr  = mem_wr ? acur[1] : acur[0];
    assign mem_wdata = mem_rdata;

    always_comb begin
        unique case (reg_addr)
            REG_CTRL:   reg_rdata = AW'({trig_sel_q, man_req_q, bcode_q, single_q, rpt_q, 1'b0, en_q});
            REG_STATUS: reg_rdata = AW'({err_q, done_q, pend, busy});
            REG_AMODE:  reg_rdata = AW'({amode[1], amode[0]});
            REG_COUNT:  reg_rdata = AW'(cnt_rem);
            REG_REPEAT: reg_rdata = AW'(rep_rem);
            REG_SRC:    reg_rdata = acur[0];
            REG_DST:    reg_rdata = acur[1];
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk (
    input logic clk,
    input logic rst,
    input logic mem_rd,
    input logic mem_wr,
    input logic busy,
    input logic pend,
    input logic en,
    input logic done_f,
    input logic err_f
);
    // R2: strobes exclusive, every write follows a read
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
    assert_wr_after_rd_R2: assert property (@(posedge clk) disable iff (rst) mem_wr |-> $past(mem_rd));
    // R12: no activity while disabled
    assert_busy_needs_en_R12: assert property (@(posedge clk) disable iff (rst) busy |-> en);
    assert_rd_needs_busy_R12: assert property (@(posedge clk) disable iff (rst) mem_rd |-> busy);
    // R8: no request is held by a disabled channel
    assert_pend_needs_en_R8: assert property (@(posedge clk) disable iff (rst) pend |-> en);
    // R9: done rises only as the enable falls
    assert_done_clears_en_R9: assert property (@(posedge clk) disable iff (rst) $rose(done_f) |-> (!en && $past(en)));
    // R10 / R11: an error always leaves the channel disabled
    assert_err_disables_R10: assert property (@(posedge clk) disable iff (rst) $rose(err_f) |-> !en);
endmodule

bind dma_channel dma_channel_chk i_chk (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr), .busy(busy),
    .pend(pend), .en(en_q), .done_f(done_q), .err_f(err_q)
);

// File: tb/test_dma_channel.sv
module test_dma_channel;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [AW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rdata;
    logic          trig_in = 1'b0;
    logic          mem_rd, mem_wr;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata = '0;
    logic [7:0]    mem_wdata;

    int checks = 0;
    int errors = 0;
    int wr_n = 0;
    logic [AW-1:0] wr_a [512];
    logic [7:0]    wr_d [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_channel i_dma_channel (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trig_in(trig_in), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // memory model: data one cycle after the read strobe
    always @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_addr);

    always @(negedge clk) begin
        if (!rst && mem_wr && wr_n < 512) begin
            wr_a[wr_n] = mem_addr;
            wr_d[wr_n] = mem_wdata;
            wr_n++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [AW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [AW-1:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [AW-1:0] s;
        for (int i = 0; i < 3000; i++) begin
            rreg(3'd1, s);
            if (s[1:0] == 2'b00) break;
        end
    endtask

    task automatic pulse_trig();
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0;
    endtask

    task automatic setup(input logic [AW-1:0] src, input logic [AW-1:0] dst,
                         input logic [7:0] am, input logic [15:0] cnt, input logic [7:0] rep);
        wreg(3'd5, src); wreg(3'd6, dst); wreg(3'd2, AW'(am));
        wreg(3'd3, AW'(cnt)); wreg(3'd4, AW'(rep));
    endtask

    task automatic t_reset();
        logic [AW-1:0] v;
        for (int r = 0; r < 7; r++) begin
            rreg(3'(r), v);
            check("R1 reset reg", 32'(v), 32'h0);
        end
        check("R1 strobes idle", {30'b0, mem_rd, mem_wr}, 32'h0);
    endtask

    task automatic t_inc_block();
        int b; logic [AW-1:0] v;
        b = wr_n;
        setup(24'h100, 24'h2000, 8'hD1, 16'd8, 8'd0);
        wreg(3'd0, 24'h51);
        wait_idle();
        check("R4 block byte count", 32'(wr_n - b), 32'd8);
        for (int i = 0; i < 8; i++) begin
            check("R2/R6 inc dst addr", 32'(wr_a[b+i]), 32'(24'h2000 + i));
            check("R2 data", 32'(wr_d[b+i]), 32'(pat(24'h100 + 24'(i))));
        end
        rreg(3'd0, v); check("R8/R9 ctrl after end", 32'(v), 32'h10);
        rreg(3'd1, v); check("R9 done set", 32'(v), 32'h4);
        rreg(3'd5, v); check("R7 src no reload", 32'(v), 32'h108);
        rreg(3'd6, v); check("R7 dst end reload", 32'(v), 32'h2000);
        wreg(3'd1, 24'h4);
        rreg(3'd1, v); check("R9 done w1c", 32'(v), 32'h0);
    endtask

    task automatic t_dec_fixed();
        int b;
        b = wr_n;
        setup(24'h50, 24'h3000, 8'h02, 16'd4, 8'd0);
        wreg(3'd0, 24'h41);
        wait_idle();
        check("R6 dec count", 32'(wr_n - b), 32'd4);
        for (int i = 0; i < 4; i++) begin
            check("R6 fixed dst", 32'(wr_a[b+i]), 32'h3000);
            check("R6 dec src data", 32'(wr_d[b+i]), 32'(pat(24'h50 - 24'(i))));
        end
        wreg(3'd1, 24'h4);
    endtask

    task automatic t_single();
        int b; logic [AW-1:0] v;
        b = wr_n;
        setup(24'h700, 24'h900, 8'h11, 16'd8, 8'd0);
        wreg(3'd0, 24'hA9);            // enable, single, burst 4, hw trigger
        @(negedge clk); trig_in = 1'b1;
        @(negedge clk); trig_in = 1'b0; reg_addr = 3'd1;
        #1 check("R12 pending before start", 32'(reg_rdata), 32'h2);
        @(negedge clk);
        #1 check("R12 busy after start", 32'(reg_rdata), 32'h1);
        wait_idle();
        check("R3 one burst per trigger", 32'(wr_n - b), 32'd4);
        rreg(3'd0, v); check("R3 still enabled", 32'(v[0]), 32'd1);
        rreg(3'd3, v); check("R4 count left", 32'(v), 32'd4);
        pulse_trig();
        wait_idle();
        check("R3 second burst", 32'(wr_n - b), 32'd8);
        for (int i = 0; i < 8; i++)
            check("R3 single data", 32'(wr_d[b+i]), 32'(pat(24'h700 + 24'(i))));
        rreg(3'd1, v); check("R9 done after bursts", 32'(v), 32'h4);
        pulse_trig();
        repeat (6) @(negedge clk);
        check("R8 trigger ignored when disabled", 32'(wr_n - b), 32'd8);
        rreg(3'd1, v); check("R8 no pending when disabled", 32'(v[1]), 32'd0);
        wreg(3'd1, 24'h4);
    endtask

    task automatic t_reload();
        int b; logic [AW-1:0] v;
        logic [7:0] exp_d [8];
        b = wr_n;
        setup(24'h400, 24'h800, 8'h95, 16'd4, 8'd2);
        wreg(3'd0, 24'h55);
        wait_idle();
        check("R5 block per trigger", 32'(wr_n - b), 32'd4);
        rreg(3'd0, v); check("R5 enabled between blocks", 32'(v[0]), 32'd1);
        wreg(3'd0, 24'h55);
        wait_idle();
        check("R5 two blocks", 32'(wr_n - b), 32'd8);
        for (int i = 0; i < 8; i++) begin
            exp_d[i] = pat(24'h400 + 24'(i % 2));
            check("R7 burst reload src", 32'(wr_d[b+i]), 32'(exp_d[i]));
            check("R7 block reload dst", 32'(wr_a[b+i]), 32'(24'h800 + 24'(i % 4)));
        end
        rreg(3'd1, v); check("R5 done after count", 32'(v), 32'h4);
        rreg(3'd5, v); check("R7 src reads base", 32'(v), 32'h400);
        wreg(3'd1, 24'h4);
    endtask

    task automatic t_forever();
        int b; logic [AW-1:0] v;
        b = wr_n;
        setup(24'h10, 24'h20, 8'h11, 16'd2, 8'd0);
        for (int k = 0; k < 3; k++) begin
            wreg(3'd0, 24'h55);
            wait_idle();
        end
        check("R5 forever bytes", 32'(wr_n - b), 32'd6);
        rreg(3'd1, v); check("R5 forever not done", 32'(v), 32'h0);
        pulse_trig();
        repeat (6) @(negedge clk);
        check("R8 trigger ignored unselected", 32'(wr_n - b), 32'd6);
        wreg(3'd0, 24'h0);
        rreg(3'd1, v); check("R10 disable after start", 32'(v), 32'h8);
        wreg(3'd1, 24'h8);
    endtask

    task automatic t_abort();
        int b, n; logic [AW-1:0] v;
        b = wr_n;
        setup(24'h1000, 24'h5000, 8'h11, 16'd64, 8'd0);
        wreg(3'd0, 24'h71);
        repeat (10) @(negedge clk);
        wreg(3'd0, 24'h0);
        n = wr_n;
        rreg(3'd1, v); check("R10 abort status", 32'(v), 32'h8);
        repeat (20) @(negedge clk);
        check("R10 no writes after abort", 32'(wr_n), 32'(n));
        check("R10 partial move", 32'(wr_n - b < 64 && wr_n - b > 0), 32'd1);
        wreg(3'd1, 24'h8);
    endtask

    task automatic t_setup_err();
        logic [AW-1:0] v;
        wreg(3'd3, 24'd6);
        wreg(3'd0, 24'h21);
        rreg(3'd1, v); check("R11 misaligned error", 32'(v), 32'h8);
        rreg(3'd0, v); check("R11 stays disabled", 32'(v[0]), 32'd0);
        wreg(3'd1, 24'h8);
        wreg(3'd3, 24'd0);
        wreg(3'd0, 24'h31);
        rreg(3'd3, v); check("R4 zero means 65536", 32'(v), 32'h10000);
        rreg(3'd1, v); check("R11 zero count aligned", 32'(v), 32'h0);
        wreg(3'd0, 24'h0);
        rreg(3'd1, v); check("R10 no error before start", 32'(v), 32'h0);
    endtask

    task automatic t_chreset();
        logic [AW-1:0] v;
        setup(24'h123, 24'h456, 8'h5A, 16'd8, 8'd3);
        wreg(3'd0, 24'h91);
        wreg(3'd0, 24'h02);
        for (int r = 0; r < 7; r++) begin
            rreg(3'(r), v);
            check("R1 channel reset", 32'(v), 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_inc_block();
        t_dec_fixed();
        t_single();
        t_reload();
        t_forever();
        t_abort();
        t_setup_err();
        t_chreset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule